// File: doc/BRIEF.md
# Calibration Parameter Table Address Translator

This block turns a logical pin request into the physical register address of that pin inside an I/O manager. A requester names an interface ID, a group number, a logical pin index and whether it wants the strobe or the data view of the pin. The block then walks a linked parameter table held in the I/O manager's memory. It issues one 32-bit read at a time through a memory-mapped read master and follows the pointers it finds until it has the lane address and the physical pin number.

The result is a 16-bit pin address of the form {lane[7:0], class nibble, pin[3:0]}, with 0xE in the class nibble for a strobe request and 0xF for a data request. A calibration routine uses that address to reach the delay controls of the pin. When the table does not describe the requested pin, the block finishes with an error flag and no address. It handles one request at a time.

Top module: `tpt_addr_xlate`

## Requirements
- R1: A request is taken when `req_valid` is high on a clock edge where the block is idle. `busy` is high from the next cycle until the result cycle. A `req_valid` seen while `busy` is high has no effect on the result. After reset `busy`, `done`, `error` and `avm_read` are low.
- R2: `done` is high for exactly one cycle per accepted request, and `busy` is low in that cycle. A new request presented in the `done` cycle is accepted.
- R3: The read master holds `avm_read` and `avm_address` steady while `avm_waitrequest` is high. It has at most one read outstanding, issues word-aligned byte addresses only, and takes `avm_readdata` only in a cycle with `avm_readdatavalid` high.
- R4: The table base is `BASE` (default byte address 0xE000). The block first reads the size word at base+0x14, then reads interface entries at base+0x18, base+0x1C and so on. An entry is valid when bits [31:28] are 0x8. It carries the ID in bits [27:24] and the byte offset of the interface descriptor in bits [23:0]. The first matching entry is used.
- R5: The lookup ends in error if the list reaches an invalid entry, if the next entry offset exceeds the size word's value in bits [15:0], or if `MAX_IF` entries have been read without a match.
- R6: The word at descriptor+4 gives the group count in bits [7:0]. A group number at or above that count ends in error.
- R7: The word at descriptor+8 holds one byte per group, group g in bits [8g+7:8g], with the lane count in bits [7:6] and the pin count in bits [5:0]. A lane count of zero, or a pin index at or above the pin count, ends in error.
- R8: The word at descriptor+0x0C+4g gives the lane-byte pointer in bits [31:16] and the pin-table pointer in bits [15:0]. Both are byte offsets from the base. The lane address is the byte at the lane-byte pointer, taken from the little-endian word that holds it.
- R9: The pin entry for logical pin p is the 16-bit halfword at pin-table pointer + 2p, with the lower address in bits [15:0]. The entry is {lane[7:0], class[3:0], pin[3:0]}. The entry's lane must equal the lane byte and its class must be 0xE or 0xF, otherwise the lookup ends in error. On success `pin_addr` = {lane, 0xE if `req_strobe` else 0xF, entry pin}.
- R10: An error result raises `error` together with `done` and drives `pin_addr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_id | input | ID_W (4) | Target interface ID |
| req_group | input | GROUP_W (2) | Group number inside the interface |
| req_pin | input | PIN_W (5) | Logical pin index inside the group |
| req_strobe | input | 1 | 1 selects the strobe view, 0 the data view |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result pulse |
| error | output | 1 | Result is an error (valid with done) |
| pin_addr | output | 16 | Composed pin address (valid with done) |
| avm_address | output | AW (24) | Read byte address |
| avm_read | output | 1 | Read strobe |
| avm_waitrequest | input | 1 | Slave stall |
| avm_readdata | input | 32 | Read data |
| avm_readdatavalid | input | 1 | Read data valid |

## Verification
The two functions that can fall in the same cycle are the result pulse and the taking of the next request. The block returns to idle in the same cycle it raises `done`, so a request raised in that cycle is taken at the next edge. The bench provokes this by chaining lookups, raising the next request in the very cycle `done` is seen. The behavioural model judges it by expecting `busy` high the cycle after and a fresh result later that matches the second request alone. A second overlap, a read-data arrival while the slave is stalling, is provoked with rotating `waitrequest` patterns and response latencies.

// File: rtl/tpt_pkg.sv
package tpt_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_SIZE,
      S_LIST,
      S_GCNT,
      S_GINFO,
      S_OFFS,
      S_LANE,
      S_PIN
   } tpt_state_t;

   localparam logic [7:0] OFF_SIZE  = 8'h14;
   localparam logic [7:0] OFF_LIST  = 8'h18;
   localparam logic [3:0] ENT_VALID = 4'h8;
   localparam logic [3:0] NIB_STB   = 4'hE;
   localparam logic [3:0] NIB_DAT   = 4'hF;

endpackage

// File: rtl/tpt_rd_master.sv
module tpt_rd_master #(
   parameter int AW = 24,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic [AW-1:0] avm_address,
   output logic          avm_read,
   input  logic          avm_waitrequest,
   input  logic [DW-1:0] avm_readdata,
   input  logic          avm_readdatavalid
);

   typedef enum logic [1:0] {M_IDLE, M_REQ, M_WAIT} mphase_t;
   mphase_t       phase;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= M_IDLE;
         addr_q <= '0;
      end else begin
         case (phase)
            M_IDLE: if (start) begin
               addr_q <= {start_addr[AW-1:2], 2'b00};
               phase  <= M_REQ;
            end
            M_REQ:  if (!avm_waitrequest) phase <= M_WAIT;
            M_WAIT: if (avm_readdatavalid) phase <= M_IDLE;
            default: phase <= M_IDLE;
         endcase
      end
   end

   assign avm_read    = (phase == M_REQ);
   assign avm_address = addr_q;
   assign rsp_valid   = (phase == M_WAIT) && avm_readdatavalid;
   assign rsp_data    = avm_readdata;

endmodule

// File: rtl/tpt_field_pick.sv
module tpt_field_pick #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] word_i,
   input  logic [1:0]    bsel,
   output logic [7:0]    byte_o,
   output logic [15:0]   half_o
);

   localparam int NB = DW / 8;
   localparam int NH = DW / 16;

   logic [7:0]  bytes [NB];
   logic [15:0] halves [NH];

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign bytes[b] = word_i[8*b +: 8];
   end
   for (genvar h = 0; h < NH; h++) begin : g_half
      assign halves[h] = word_i[16*h +: 16];
   end

   assign byte_o = bytes[bsel];
   assign half_o = halves[bsel[1]];

endmodule

// File: rtl/tpt_addr_xlate.sv
module tpt_addr_xlate
   import tpt_pkg::*;
#(
   parameter int            AW      = 24,
   parameter logic [AW-1:0] BASE    = 24'h00E000,
   parameter int            ID_W    = 4,
   parameter int            GROUP_W = 2,
   parameter int            PIN_W   = 5,
   parameter int            MAX_IF  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [ID_W-1:0]    req_id,
   input  logic [GROUP_W-1:0] req_group,
   input  logic [PIN_W-1:0]   req_pin,
   input  logic               req_strobe,
   output logic               busy,
   output logic               done,
   output logic               error,
   output logic [15:0]        pin_addr,
   output logic [AW-1:0]      avm_address,
   output logic               avm_read,
   input  logic               avm_waitrequest,
   input  logic [31:0]        avm_readdata,
   input  logic               avm_readdatavalid
);

   localparam int CNT_W = $clog2(MAX_IF + 1);
   localparam int OW    = 24;

   if (AW < 17 || AW > 32) begin : g_bad_aw
      $error("tpt_addr_xlate: AW must be within 17..32");
   end
   if (GROUP_W < 1 || GROUP_W > 2) begin : g_bad_grp
      $error("tpt_addr_xlate: GROUP_W must be 1 or 2");
   end
   if (ID_W != 4) begin : g_bad_id
      $error("tpt_addr_xlate: ID_W must be 4");
   end
   if (PIN_W < 1 || PIN_W > 6) begin : g_bad_pin
      $error("tpt_addr_xlate: PIN_W must be within 1..6");
   end
   if (MAX_IF < 1) begin : g_bad_if
      $error("tpt_addr_xlate: MAX_IF must be at least 1");
   end

   tpt_state_t         state;
   logic [ID_W-1:0]    q_id;
   logic [GROUP_W-1:0] q_grp;
   logic [PIN_W-1:0]   q_pin;
   logic               q_stb;
   logic [15:0]        tsize;
   logic [15:0]        cur_off;
   logic [CNT_W-1:0]   if_cnt;
   logic [OW-1:0]      desc;
   logic [1:0]         lane_sel;
   logic               half_sel;
   logic [7:0]         lane_byte;

   logic               rd_start;
   logic [OW-1:0]      rd_off;
   logic [AW-1:0]      rd_addr;
   logic               rsp_valid;
   logic [31:0]        rsp_data;

   logic [1:0]         pick_sel;
   logic [7:0]         pick_byte;
   logic [15:0]        pick_half;
   logic [1:0]         grp2;
   logic [16:0]        next_off;
   logic [15:0]        pin_loc;
   logic [7:0]         pin_lim;
   logic [7:0]         pin_req;
   logic [7:0]         grp_req;

   assign rd_addr  = BASE + AW'(rd_off);
   assign grp2     = 2'(q_grp);
   assign next_off = {1'b0, cur_off} + 17'd4;
   assign pin_loc  = rsp_data[15:0] + (16'(q_pin) << 1);
   assign pin_lim  = {2'b00, pick_byte[5:0]};
   assign pin_req  = 8'(q_pin);
   assign grp_req  = 8'(q_grp);

   always_comb begin
      case (state)
         S_GINFO: pick_sel = grp2;
         S_LANE:  pick_sel = lane_sel;
         default: pick_sel = {half_sel, 1'b0};
      endcase
   end

   tpt_rd_master #(.AW(AW), .DW(32)) u_rdm (
      .clk               (clk),
      .rst_n             (rst_n),
      .start             (rd_start),
      .start_addr        (rd_addr),
      .rsp_valid         (rsp_valid),
      .rsp_data          (rsp_data),
      .avm_address       (avm_address),
      .avm_read          (avm_read),
      .avm_waitrequest   (avm_waitrequest),
      .avm_readdata      (avm_readdata),
      .avm_readdatavalid (avm_readdatavalid)
   );

   tpt_field_pick #(.DW(32)) u_pick (
      .word_i (rsp_data),
      .bsel   (pick_sel),
      .byte_o (pick_byte),
      .half_o (pick_half)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         q_id      <= '0;
         q_grp     <= '0;
         q_pin     <= '0;
         q_stb     <= 1'b0;
         tsize     <= '0;
         cur_off   <= '0;
         if_cnt    <= '0;
         desc      <= '0;
         lane_sel  <= '0;
         half_sel  <= 1'b0;
         lane_byte <= '0;
         rd_start  <= 1'b0;
         rd_off    <= '0;
         done      <= 1'b0;
         error     <= 1'b0;
         pin_addr  <= '0;
      end else begin
         rd_start <= 1'b0;
         done     <= 1'b0;
         error    <= 1'b0;
         case (state)
            S_IDLE: begin
               if (req_valid) begin
                  q_id     <= req_id;
                  q_grp    <= req_group;
                  q_pin    <= req_pin;
                  q_stb    <= req_strobe;
                  rd_start <= 1'b1;
                  rd_off   <= OW'(OFF_SIZE);
                  state    <= S_SIZE;
               end
            end
            S_SIZE: if (rsp_valid) begin
               tsize <= rsp_data[15:0];
               if (16'(OFF_LIST) > rsp_data[15:0]) begin
                  state <= S_IDLE; done <= 1'b1; error <= 1'b1; pin_addr <= '0;
               end else begin
                  cur_off  <= 16'(OFF_LIST);
                  if_cnt   <= CNT_W'(1);
                  rd_start <= 1'b1;
                  rd_off   <= OW'(OFF_LIST);
                  state    <= S_LIST;
               end
            end
            S_LIST: if (rsp_valid) begin
               if (rsp_data[31:28] != ENT_VALID) begin
                  state <= S_IDLE; done <= 1'b1; error <= 1'b1; pin_addr <= '0;
               end else if (rsp_data[27:24] == q_id) begin
                  desc     <= rsp_data[23:0];
                  rd_start <= 1'b1;
                  rd_off   <= rsp_data[23:0] + 24'd4;
                  state    <= S_GCNT;
               end else if (if_cnt == CNT_W'(MAX_IF) || next_off > {1'b0, tsize}) begin
                  state <= S_IDLE; done <= 1'b1; error <= 1'b1; pin_addr <= '0;
               end else begin
                  cur_off  <= next_off[15:0];
                  if_cnt   <= if_cnt + 1'b1;
                  rd_start <= 1'b1;
                  rd_off   <= OW'(next_off[15:0]);
               end
            end
            S_GCNT: if (rsp_valid) begin
               if (grp_req >= rsp_data[7:0]) begin
                  state <= S_IDLE; done <= 1'b1; error <= 1'b1; pin_addr <= '0;
               end else begin
                  rd_start <= 1'b1;
                  rd_off   <= desc + 24'd8;
                  state    <= S_GINFO;
               end
            end
            S_GINFO: if (rsp_valid) begin
               if (pick_byte[7:6] == 2'b00 || pin_req >= pin_lim) begin
                  state <= S_IDLE; done <= 1'b1; error <= 1'b1; pin_addr <= '0;
               end else begin
                  rd_start <= 1'b1;
                  rd_off   <= desc + 24'd12 + (OW'(q_grp) << 2);
                  state    <= S_OFFS;
               end
            end
            S_OFFS: if (rsp_valid) begin
               lane_sel <= rsp_data[17:16];
               half_sel <= pin_loc[1];
               desc     <= OW'({pin_loc[15:2], 2'b00});
               rd_start <= 1'b1;
               rd_off   <= OW'({rsp_data[31:18], 2'b00});
               state    <= S_LANE;
            end
            S_LANE: if (rsp_valid) begin
               lane_byte <= pick_byte;
               rd_start  <= 1'b1;
               rd_off    <= desc;
               state     <= S_PIN;
            end
            S_PIN: if (rsp_valid) begin
               state <= S_IDLE;
               done  <= 1'b1;
               if (pick_half[15:8] != lane_byte || pick_half[7:5] != 3'b111) begin
                  error    <= 1'b1;
                  pin_addr <= '0;
               end else begin
                  pin_addr <= {lane_byte, (q_stb ? NIB_STB : NIB_DAT), pick_half[3:0]};
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy = (state != S_IDLE);

endmodule

// File: rtl/tpt_addr_xlate_chk.sv
module tpt_addr_xlate_chk #(
   parameter int AW      = 24,
   parameter int ID_W    = 4,
   parameter int GROUP_W = 2,
   parameter int PIN_W   = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [ID_W-1:0]    req_id,
   input logic [GROUP_W-1:0] req_group,
   input logic [PIN_W-1:0]   req_pin,
   input logic               req_strobe,
   input logic               busy,
   input logic               done,
   input logic               error,
   input logic [15:0]        pin_addr,
   input logic [AW-1:0]      avm_address,
   input logic               avm_read,
   input logic               avm_waitrequest,
   input logic [31:0]        avm_readdata,
   input logic               avm_readdatavalid
);

   p_start_on_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   p_no_read_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !avm_read);

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   p_hold_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (avm_read && avm_waitrequest) |=> (avm_read && $stable(avm_address)));

   p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      avm_read |-> (avm_address[1:0] == 2'b00));

   p_class_nibble_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !error) |-> (pin_addr[7:4] == 4'hE || pin_addr[7:4] == 4'hF));

   p_err_no_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (done && pin_addr == 16'h0000));

endmodule

bind tpt_addr_xlate tpt_addr_xlate_chk #(
   .AW(AW), .ID_W(ID_W), .GROUP_W(GROUP_W), .PIN_W(PIN_W)
) u_chk (.*);

// File: tb/tpt_addr_xlate_test.sv
module tpt_addr_xlate_test;

   localparam int N_IF = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_id = '0;
   logic [1:0]  req_group = '0;
   logic [4:0]  req_pin = '0;
   logic        req_strobe = 1'b0;
   logic        busy, done, error;
   logic [15:0] pin_addr;
   logic [23:0] avm_address;
   logic        avm_read;
   logic        avm_waitrequest;
   logic [31:0] avm_readdata;
   logic        avm_readdatavalid;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   tpt_addr_xlate #(.MAX_IF(N_IF)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
      .req_group(req_group), .req_pin(req_pin), .req_strobe(req_strobe),
      .busy(busy), .done(done), .error(error), .pin_addr(pin_addr),
      .avm_address(avm_address), .avm_read(avm_read),
      .avm_waitrequest(avm_waitrequest), .avm_readdata(avm_readdata),
      .avm_readdatavalid(avm_readdatavalid)
   );

   // ---------------- memory model ----------------
   logic [31:0] mem [0:63];
   logic [7:0]  wr_pat = 8'h00;
   int          lat_cfg = 0;
   logic        pend = 1'b0;
   int          lat = 0;
   logic [31:0] pdata = '0;
   logic        rdv = 1'b0;
   logic [31:0] rdat = '0;

   function automatic logic [31:0] rdw(input int off);
      if (off >= 0 && off < 256) return mem[off >> 2];
      return 32'h0;
   endfunction

   assign avm_waitrequest   = wr_pat[0];
   assign avm_readdatavalid = rdv;
   assign avm_readdata      = rdat;

   always @(posedge clk) begin
      wr_pat <= {wr_pat[0], wr_pat[7:1]};
      rdv    <= 1'b0;
      rdat   <= 32'h0;
      if (pend) begin
         if (lat == 0) begin
            rdv <= 1'b1; rdat <= pdata; pend <= 1'b0;
         end else lat <= lat - 1;
      end
      if (avm_read && !avm_waitrequest) begin
         pend  <= 1'b1;
         pdata <= rdw(int'(avm_address) - 32'hE000);
         lat   <= lat_cfg;
      end
   end

   task automatic put_half(input int off, input logic [15:0] v);
      if (off[1]) mem[off >> 2][31:16] = v;
      else        mem[off >> 2][15:0]  = v;
   endtask

   task automatic build_table();
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      mem[8'h14 >> 2] = 32'h0000_00A8;
      mem[8'h18 >> 2] = 32'h8400_0044;
      mem[8'h1C >> 2] = 32'h8500_0074;
      mem[8'h20 >> 2] = 32'h8600_0044;
      mem[8'h24 >> 2] = 32'h8700_0044;
      mem[8'h28 >> 2] = 32'h0000_0000;
      mem[8'h48 >> 2] = 32'h0000_0002;
      mem[8'h4C >> 2] = 32'h0000_4646;
      mem[8'h50 >> 2] = 32'h0058_005C;
      mem[8'h54 >> 2] = 32'h0059_0068;
      mem[8'h58 >> 2] = 32'h0000_3930;
      mem[8'h5C >> 2] = 32'h30E5_30E4;
      mem[8'h60 >> 2] = 32'h30F7_30F6;
      mem[8'h64 >> 2] = 32'h30F1_30F0;
      mem[8'h68 >> 2] = 32'h39E5_39E4;
      mem[8'h6C >> 2] = 32'h39F6_39F9;
      mem[8'h70 >> 2] = 32'h39F8_39F3;
      mem[8'h78 >> 2] = 32'h0000_0003;
      mem[8'h7C >> 2] = 32'h0044_4248;
      mem[8'h80 >> 2] = 32'h008C_0090;
      mem[8'h84 >> 2] = 32'h008D_00A0;
      mem[8'h88 >> 2] = 32'h008E_00A4;
      mem[8'h8C >> 2] = 32'h0022_1110;
      for (int i = 0; i < 8; i++)
         put_half(8'h90 + 2*i, {8'h10, (i < 2) ? 4'hE : 4'hF, 4'(i*3+1)});
      for (int i = 0; i < 2; i++)
         put_half(8'hA0 + 2*i, {8'h11, (i < 2) ? 4'hE : 4'hF, 4'(i*3+1)});
      for (int i = 0; i < 4; i++)
         put_half(8'hA4 + 2*i, {8'h22, (i < 2) ? 4'hE : 4'hF, 4'(i*3+1)});
   endtask

   // ---------------- behavioural reference ----------------
   function automatic void ref_lookup(input int id, input int g, input int p, input bit s,
                                      output bit err, output logic [15:0] a);
      int off, cnt, size, desc, gc, info, lanep, pinp, loc;
      logic [31:0] w;
      logic [7:0]  lb;
      logic [15:0] e;
      bit found;
      err = 1'b1; a = 16'h0;
      size = int'(rdw(32'h14) & 32'hFFFF);
      off = 32'h18; cnt = 0; desc = 0; found = 1'b0;
      while (!found) begin
         if (off > size || cnt == N_IF) return;
         w = rdw(off); cnt++;
         if (w[31:28] != 4'h8) return;
         if (int'(w[27:24]) == id) begin desc = int'(w[23:0]); found = 1'b1; end
         else off += 4;
      end
      gc = int'(rdw(desc + 4) & 32'hFF);
      if (g >= gc) return;
      info = int'((rdw(desc + 8) >> (8*g)) & 32'hFF);
      if ((info >> 6) == 0 || p >= (info & 63)) return;
      w = rdw(desc + 12 + 4*g);
      lanep = int'(w[31:16]); pinp = int'(w[15:0]);
      lb = 8'(rdw(lanep & ~3) >> (8*(lanep & 3)));
      loc = pinp + 2*p;
      e = 16'(rdw(loc & ~3) >> (16*((loc >> 1) & 1)));
      if (e[15:8] != lb || e[7:4] < 4'hE) return;
      err = 1'b0;
      a = {lb, s ? 4'hE : 4'hF, e[3:0]};
   endfunction

   // ---------------- per-clock comparison ----------------
   bit          pending = 1'b0;
   bit          exp_err;
   logic [15:0] exp_addr;
   string       exp_tag = "R4";
   logic        busy_prev = 1'b0;
   logic        rd_prev = 1'b0, wr_prev = 1'b0;
   logic [23:0] ad_prev = '0;
   bit          mon_on = 1'b0;

   always @(negedge clk) begin
      cycles++;
      if (mon_on) begin
         if (done) begin
            checks++;
            if (!pending) begin
               errors++;
               $display("FAIL R2: done=%0d while no request pending, expected 0", done);
            end else if (error !== exp_err || pin_addr !== exp_addr) begin
               errors++;
               $display("FAIL %s: error=%0d pin_addr=%h, expected error=%0d pin_addr=%h",
                        exp_tag, error, pin_addr, exp_err, exp_addr);
            end
            pending = 1'b0;
         end
         if (req_valid && !busy_prev) begin
            pending = 1'b1;
            ref_lookup(int'(req_id), int'(req_group), int'(req_pin), req_strobe, exp_err, exp_addr);
         end
         checks++;
         if (busy !== pending) begin
            errors++;
            $display("FAIL R1: busy=%0d expected %0d", busy, pending);
         end
         if (rd_prev && wr_prev) begin
            checks++;
            if (!avm_read || avm_address !== ad_prev) begin
               errors++;
               $display("FAIL R3: read=%0d addr=%h under stall, expected 1 addr=%h",
                        avm_read, avm_address, ad_prev);
            end
         end
      end
      busy_prev = busy;
      rd_prev = avm_read; wr_prev = avm_waitrequest; ad_prev = avm_address;
   end

   // ---------------- stimulus ----------------
   task automatic wait_idle();
      @(negedge clk); #1;
      while (busy) begin @(negedge clk); #1; end
   endtask

   task automatic wait_done();
      @(negedge clk); #1;
      while (!done) begin @(negedge clk); #1; end
   endtask

   task automatic issue(input int id, input int g, input int p, input bit s);
      req_valid = 1'b1; req_id = 4'(id); req_group = 2'(g); req_pin = 5'(p); req_strobe = s;
      @(negedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic lookup(input string tag, input int id, input int g, input int p, input bit s);
      wait_idle();
      exp_tag = tag;
      issue(id, g, p, s);
      wait_done();
   endtask

   task automatic check_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      build_table();
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check_val("R1", {12'h0, busy, done, error, avm_read}, 16'h0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk); #1;
      check_val("R1", {12'h0, busy, done, error, avm_read}, 16'h0);

      // R4 R8 R9: basic strobe and data lookups
      lookup("R9", 4, 0, 0, 1'b1);
      check_val("R9", pin_addr, 16'h30E4);
      lookup("R8", 4, 1, 3, 1'b0);
      check_val("R8", pin_addr, 16'h39F6);
      lookup("R4", 6, 0, 1, 1'b0);
      check_val("R4", pin_addr, 16'h30F5);

      // R3: stalls and latency
      wr_pat = 8'b0110_1101; lat_cfg = 2;
      lookup("R3", 5, 2, 3, 1'b1);
      check_val("R3", pin_addr, 16'h22EA);
      lookup("R7", 5, 1, 1, 1'b0);
      check_val("R7", pin_addr, 16'h11F4);
      wr_pat = 8'b0000_0011; lat_cfg = 0;

      // R5 R10: absent ID, list bound, size bound
      lookup("R5", 9, 0, 0, 1'b0);
      check_val("R10", {15'h0, error}, 16'h1);
      lookup("R5", 7, 0, 0, 1'b0);
      check_val("R5", {15'h0, error}, 16'h1);
      mem[8'h14 >> 2] = 32'h0000_0018;
      lookup("R5", 5, 0, 0, 1'b0);
      check_val("R5", {15'h0, error}, 16'h1);
      mem[8'h14 >> 2] = 32'h0000_00A8;

      // R6 R7: group and pin range
      lookup("R6", 4, 2, 0, 1'b0);
      check_val("R6", {15'h0, error}, 16'h1);
      lookup("R7", 4, 0, 6, 1'b0);
      check_val("R7", {15'h0, error}, 16'h1);
      lookup("R7", 5, 1, 2, 1'b1);
      check_val("R7", {15'h0, error}, 16'h1);

      // R9: corrupt entry lane
      mem[8'h5C >> 2] = 32'h30E5_31E4;
      lookup("R9", 4, 0, 0, 1'b1);
      check_val("R9", {15'h0, error}, 16'h1);
      mem[8'h5C >> 2] = 32'h30E5_30E4;

      // R1: requests while busy are ignored
      wait_idle();
      exp_tag = "R1";
      issue(4, 0, 0, 1'b1);
      req_valid = 1'b1; req_id = 4'd5; req_group = 2'd2; req_pin = 5'd3; req_strobe = 1'b0;
      repeat (4) begin @(negedge clk); #1; end
      req_valid = 1'b0;
      wait_done();
      check_val("R1", pin_addr, 16'h30E4);

      // R2: next request raised in the done cycle
      wait_idle();
      exp_tag = "R2";
      issue(4, 1, 0, 1'b1);
      wait_done();
      check_val("R2", pin_addr, 16'h39E4);
      issue(5, 0, 7, 1'b0);
      check_val("R2", {15'h0, busy}, 16'h1);
      wait_done();
      check_val("R2", pin_addr, 16'h10F6);

      repeat (4) @(negedge clk);
      finish_run();
   end

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

endmodule